// File: doc/BRIEF.md
# Soft Power-Down Mode Controller

This block decides when a small networking device sleeps and when it runs. Software writes a two-bit mode field in a power-management control register through a simple host register port. The value `2'b10` puts the device into soft power-down. In that state the controller drops every PLL-derived clock enable and every PHY and MAC enable. It also returns the configuration register bank to its default contents.

While the device sleeps, the host port still works, but only so that software can wake the device. The mode register still accepts writes and reads, and the configuration bank is closed to the host. Writing any other mode value wakes the device. On the clock edge that leaves power-down, the strap-in inputs are captured into a latched strap word and a one-cycle strobe marks the capture. The subsystem enables return one cycle after that strobe. Leaving reset follows the same strap-capture sequence.

Top module: `pdn_ctrl`

## Requirements
- R1: After reset is released, the first clock edge raises `strap_stb` for one cycle and loads `strap_cfg` from `strap_in`. All enables stay low in that cycle and go high on the next edge.
- R2: A host write of `2'b10` to bits [1:0] at address 0 sets `pwrdn` on the next clock edge. Every bit of `pll_clk_en`, `phy_en` and `mac_en` is low for as long as `pwrdn` is high. Writing `2'b10` again while asleep keeps the device asleep.
- R3: The mode values `2'b00`, `2'b01` and `2'b11` are all normal operation. With any of them, `pwrdn` stays low and all enables stay high.
- R4: On the edge that enters power-down, `cfg_clr` pulses for exactly one cycle. Each configuration register at address a (1 to NUM_CFG) returns to its default, (37·a + 5) mod 2^DATA_W.
- R5: While `pwrdn` is high, host writes to configuration addresses are ignored and reads of them return 0.
- R6: The mode register is never cleared by power-down entry. A read of address 0 returns the last written mode in bits [1:0], with the upper bits zero.
- R7: While asleep, a write of any mode value other than `2'b10` clears `pwrdn` on the next edge. On that same edge `strap_stb` is high for exactly one cycle and `strap_cfg` takes the value of `strap_in`. `strap_cfg` holds at all other times.
- R8: The enables reassert on the edge after the one that raised `strap_stb`.
- R9: In normal operation, configuration registers read back the last value written. Addresses above NUM_CFG read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host register address (0 = mode register) |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data for `host_addr` (combinational) |
| strap_in | input | STRAP_W | Strap-in inputs |
| strap_cfg | output | STRAP_W | Latched strap word |
| strap_stb | output | 1 | One-cycle strap capture strobe |
| pll_clk_en | output | NUM_PLL | PLL-derived clock enables |
| phy_en | output | NUM_PORT | PHY enables |
| mac_en | output | NUM_PORT | MAC enables |
| cfg_clr | output | 1 | One-cycle default-restore strobe on power-down entry |
| pwrdn | output | 1 | High while in soft power-down |

## Verification
The bench builds the block with its defaults: six 8-bit configuration registers, a 3-bit address space that includes one unmapped address, three PLL enables, two ports and a 4-bit strap word. With this configuration the bench can sweep every address on each pass. It can also put all four mode encodings through every state, and run a full sleep-and-wake cycle for each of the three wake encodings, each with its own strap pattern. Every register default is computed in the bench from the stated formula.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_SLEEP = 2'd2
    } pdn_state_e;

    localparam logic [1:0] MODE_SLEEP = 2'b10;

    // Default contents of configuration register at host address idx.
    function automatic logic [31:0] cfg_default(input int unsigned idx);
        return 32'(idx * 37 + 5);
    endfunction

endpackage

// File: rtl/pdn_seq.sv
module pdn_seq
    import pdn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    output pdn_state_e state,
    output logic       clr_now,
    output logic       cap_now,
    output logic       strap_stb,
    output logic       sub_en,
    output logic       cfg_clr
);

    typedef struct packed {
        pdn_state_e st;
        logic       stb;
        logic       en;
        logic       clr;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_INIT:  seq_d.st = ST_RUN;
            ST_RUN:   if (mode == MODE_SLEEP) seq_d.st = ST_SLEEP;
            ST_SLEEP: if (mode != MODE_SLEEP) seq_d.st = ST_RUN;
            default:  seq_d.st = ST_INIT;
        endcase
        seq_d.stb = (seq_q.st != ST_RUN) && (seq_d.st == ST_RUN);
        seq_d.en  = (seq_q.st == ST_RUN) && (seq_d.st == ST_RUN);
        seq_d.clr = (seq_q.st == ST_RUN) && (seq_d.st == ST_SLEEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_INIT, stb: 1'b0, en: 1'b0, clr: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state     = seq_q.st;
    assign clr_now   = seq_d.clr;
    assign cap_now   = seq_d.stb;
    assign strap_stb = seq_q.stb;
    assign sub_en    = seq_q.en;
    assign cfg_clr   = seq_q.clr;

endmodule

// File: rtl/pdn_regs.sv
module pdn_regs
    import pdn_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_CFG = 6,
    parameter int ADDR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              open,
    input  logic              clear,
    output logic [1:0]        mode,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [1:0]                         mode;
        logic [NUM_CFG-1:0][DATA_W-1:0]     cfg;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [NUM_CFG-1:0][DATA_W-1:0] dflt;

    for (genvar k = 0; k < NUM_CFG; k++) begin : g_dflt
        assign dflt[k] = DATA_W'(cfg_default(k + 1));
    end

    always_comb begin
        regs_d = regs_q;
        if (we && addr == '0) begin
            regs_d.mode = wdata[1:0];
        end
        for (int k = 0; k < NUM_CFG; k++) begin
            if (clear) begin
                regs_d.cfg[k] = dflt[k];
            end else if (we && open && addr == ADDR_W'(k + 1)) begin
                regs_d.cfg[k] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{mode: 2'b00, cfg: dflt};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == '0) begin
            rdata[1:0] = regs_q.mode;
        end else if (open) begin
            for (int k = 0; k < NUM_CFG; k++) begin
                if (addr == ADDR_W'(k + 1)) rdata = regs_q.cfg[k];
            end
        end
    end

    assign mode = regs_q.mode;

endmodule

// File: rtl/pdn_strap.sv
module pdn_strap #(
    parameter int STRAP_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [STRAP_W-1:0] pins,
    output logic [STRAP_W-1:0] latched
);

    logic [STRAP_W-1:0] lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (capture) lat_d = pins;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign latched = lat_q;

endmodule

// File: rtl/pdn_ctrl.sv
module pdn_ctrl
    import pdn_pkg::*;
#(
    parameter int  DATA_W   = 8,
    parameter int  NUM_CFG  = 6,
    parameter int  NUM_PLL  = 3,
    parameter int  NUM_PORT = 2,
    parameter int  STRAP_W  = 4,
    localparam int ADDR_W   = $clog2(NUM_CFG + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    input  logic [STRAP_W-1:0]  strap_in,
    output logic [STRAP_W-1:0]  strap_cfg,
    output logic                strap_stb,
    output logic [NUM_PLL-1:0]  pll_clk_en,
    output logic [NUM_PORT-1:0] phy_en,
    output logic [NUM_PORT-1:0] mac_en,
    output logic                cfg_clr,
    output logic                pwrdn
);

    pdn_state_e state;
    logic [1:0] mode;
    logic       clr_now, cap_now, sub_en;

    pdn_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .state     (state),
        .clr_now   (clr_now),
        .cap_now   (cap_now),
        .strap_stb (strap_stb),
        .sub_en    (sub_en),
        .cfg_clr   (cfg_clr)
    );

    pdn_regs #(
        .DATA_W  (DATA_W),
        .NUM_CFG (NUM_CFG),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (host_we),
        .addr  (host_addr),
        .wdata (host_wdata),
        .open  (state == ST_RUN),
        .clear (clr_now),
        .mode  (mode),
        .rdata (host_rdata)
    );

    pdn_strap #(
        .STRAP_W (STRAP_W)
    ) u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_now),
        .pins    (strap_in),
        .latched (strap_cfg)
    );

    for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
        assign pll_clk_en[g] = sub_en;
    end

    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        assign phy_en[p] = sub_en;
        assign mac_en[p] = sub_en;
    end

    assign pwrdn = (state == ST_SLEEP);

endmodule

// File: rtl/pdn_ctrl_chk.sv
module pdn_ctrl_chk #(
    parameter int DATA_W   = 8,
    parameter int NUM_PLL  = 3,
    parameter int NUM_PORT = 2,
    parameter int STRAP_W  = 4,
    parameter int ADDR_W   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   host_addr,
    input logic [DATA_W-1:0]   host_rdata,
    input logic [STRAP_W-1:0]  strap_cfg,
    input logic                strap_stb,
    input logic [NUM_PLL-1:0]  pll_clk_en,
    input logic [NUM_PORT-1:0] phy_en,
    input logic [NUM_PORT-1:0] mac_en,
    input logic                cfg_clr,
    input logic                pwrdn
);

    p_sleep_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn |-> (pll_clk_en == '0 && phy_en == '0 && mac_en == '0));

    p_entry_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwrdn) |-> cfg_clr);

    p_clear_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clr |=> !cfg_clr);

    p_closed_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrdn && host_addr != '0) |-> host_rdata == '0);

    p_wake_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwrdn) |-> strap_stb);

    p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strap_stb |=> !strap_stb);

    p_strap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_stb |-> $stable(strap_cfg));

    p_enable_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_stb && !pwrdn) |=> (&pll_clk_en && &phy_en && &mac_en));

endmodule

bind pdn_ctrl pdn_ctrl_chk #(
    .DATA_W   (DATA_W),
    .NUM_PLL  (NUM_PLL),
    .NUM_PORT (NUM_PORT),
    .STRAP_W  (STRAP_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .strap_cfg  (strap_cfg),
    .strap_stb  (strap_stb),
    .pll_clk_en (pll_clk_en),
    .phy_en     (phy_en),
    .mac_en     (mac_en),
    .cfg_clr    (cfg_clr),
    .pwrdn      (pwrdn)
);

// File: tb/sim_pdn_ctrl.sv
module sim_pdn_ctrl;

    localparam int DATA_W   = 8;
    localparam int NUM_CFG  = 6;
    localparam int NUM_PLL  = 3;
    localparam int NUM_PORT = 2;
    localparam int STRAP_W  = 4;
    localparam int ADDR_W   = $clog2(NUM_CFG + 1);
    localparam int NUM_ADDR = 1 << ADDR_W;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                host_we = 1'b0;
    logic [ADDR_W-1:0]   host_addr = '0;
    logic [DATA_W-1:0]   host_wdata = '0;
    logic [DATA_W-1:0]   host_rdata;
    logic [STRAP_W-1:0]  strap_in = 4'h9;
    logic [STRAP_W-1:0]  strap_cfg;
    logic                strap_stb;
    logic [NUM_PLL-1:0]  pll_clk_en;
    logic [NUM_PORT-1:0] phy_en, mac_en;
    logic                cfg_clr, pwrdn;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pdn_ctrl #(
        .DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .NUM_PLL(NUM_PLL),
        .NUM_PORT(NUM_PORT), .STRAP_W(STRAP_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .strap_in(strap_in),
        .strap_cfg(strap_cfg), .strap_stb(strap_stb), .pll_clk_en(pll_clk_en),
        .phy_en(phy_en), .mac_en(mac_en), .cfg_clr(cfg_clr), .pwrdn(pwrdn)
    );

    function automatic int dflt(input int a);
        return (37 * a + 5) % (1 << DATA_W);
    endfunction

    function automatic int en_word();
        return int'({pll_clk_en, phy_en, mac_en});
    endfunction

    localparam int EN_ALL = (1 << (NUM_PLL + 2 * NUM_PORT)) - 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        host_we    = 1'b1;
        host_addr  = ADDR_W'(a);
        host_wdata = DATA_W'(d);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        host_addr = ADDR_W'(a);
        #1;
        chk(req, int'(host_rdata), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 strobe after reset", int'(strap_stb), 1);
        chk("R1 strap latched", int'(strap_cfg), 9);
        chk("R1 enables low", en_word(), 0);
        @(negedge clk);
        chk("R1 strobe single", int'(strap_stb), 0);
        chk("R8 enables high after reset", en_word(), EN_ALL);
        chk("R3 awake after reset", int'(pwrdn), 0);
        for (int a = 1; a <= NUM_CFG; a++) rd_chk("R4 reset default", a, dflt(a));

        // R9: write and read back every address
        for (int a = 1; a < NUM_ADDR; a++) wr(a, (a * 29 + 3) & 8'hFF);
        for (int a = 1; a < NUM_ADDR; a++)
            rd_chk("R9 readback", a, (a <= NUM_CFG) ? ((a * 29 + 3) & 8'hFF) : 0);

        // R3: non-sleep encodings
        for (int m = 0; m < 4; m++) begin
            if (m == 2) continue;
            wr(0, 8'hFC | m);
            @(negedge clk);
            chk("R3 no power-down", int'(pwrdn), 0);
            chk("R3 enables stay", en_word(), EN_ALL);
            rd_chk("R6 mode readback", 0, m);
        end

        // Full sleep/wake per wake encoding
        for (int w = 0; w < 4; w++) begin
            if (w == 2) continue;
            for (int a = 1; a <= NUM_CFG; a++) wr(a, (a * 13 + w + 1) & 8'hFF);
            wr(0, 2);
            chk("R2 not yet asleep", int'(pwrdn), 0);
            @(negedge clk);
            chk("R2 asleep", int'(pwrdn), 1);
            chk("R2 enables off", en_word(), 0);
            chk("R4 clear strobe", int'(cfg_clr), 1);
            @(negedge clk);
            chk("R4 clear single", int'(cfg_clr), 0);
            for (int a = 1; a < NUM_ADDR; a++) rd_chk("R5 closed read", a, 0);
            rd_chk("R6 mode kept", 0, 2);
            wr(1, 8'h5A);
            wr(0, 2);
            @(negedge clk);
            chk("R2 stays asleep", int'(pwrdn), 1);
            strap_in = STRAP_W'(w * 5 + 2);
            wr(0, w);
            chk("R7 asleep until edge", int'(pwrdn), 1);
            chk("R7 no early strobe", int'(strap_stb), 0);
            @(negedge clk);
            chk("R7 awake", int'(pwrdn), 0);
            chk("R7 strobe", int'(strap_stb), 1);
            chk("R7 strap value", int'(strap_cfg), (w * 5 + 2) & 4'hF);
            chk("R8 enables wait", en_word(), 0);
            strap_in = ~strap_in;
            @(negedge clk);
            chk("R7 strobe single", int'(strap_stb), 0);
            chk("R7 strap held", int'(strap_cfg), (w * 5 + 2) & 4'hF);
            chk("R8 enables back", en_word(), EN_ALL);
            rd_chk("R6 wake mode", 0, w);
            for (int a = 1; a <= NUM_CFG; a++) rd_chk("R4 R5 defaults restored", a, dflt(a));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule